// File: doc/BRIEF.md
# Nested Exception Escalation Unit

This unit sits between the fault sources of a processor core and its exception delivery logic. Each request names a vector, an error code, whether it is a software interrupt, and how many bytes to add to the current instruction pointer. The unit decides whether the new exception combines with the exception already being delivered. If it does, the result is a double fault (vector 8) or a triple fault. A triple fault produces a halt indication and a shutdown request, or a guest-exit request when the core is running a guest.

The unit keeps a history register that holds the most recent escalation-relevant vector, together with a valid bit. The history is cleared when the delivery logic reports that delivery is complete, so a stale vector cannot cause a false escalation.

Two request kinds have fixed content and are built inside the unit:
- the single-step breakpoint trap;
- the misaligned-access fault from alignment-checking vector instructions.

The result is presented one cycle after acceptance as a single valid pulse.

Control is a two-state machine:
- **READY**: requests are accepted (`req_ready` high).
  - Transition *TRIPLE*: an accepted exception meets a history of vector 8, and the machine moves to HALT.
  - A `delivery_done` pulse in READY clears the history and the machine stays in READY.
- **HALT**: requests are held off, and the shutdown or guest-exit request is held high.
  - Transition *RELEASE*: a `delivery_done` pulse returns the machine to READY and clears the history.

Top module: `exc_escalator`

## Requirements
- R1: After reset, `out_valid`, `shutdown_req` and `guest_exit_req` are 0, `req_ready` is 1, and the history is empty. A first exception of vector 13 is delivered as 13 with its own error code.
- R2: Vectors 0, 10, 11, 12 and 13 are contributory. A contributory exception arriving while the history holds a contributory vector is delivered as vector 8 with error code 0.
- R3: While the history holds 14, a contributory exception or vector 14 is delivered as vector 8 with error code 0. Any other combination is delivered with the request's own vector and error code.
- R4: An exception arriving while the history holds 8 is a triple fault. The result has `out_halt`=1 and vector 0, and from the next cycle `shutdown_req` stays high and `req_ready` stays low until `delivery_done`.
- R5: If `guest_mode` is 1 when a triple fault is accepted, `guest_exit_req` is raised instead of `shutdown_req`. The two are never high together.
- R6: The history is loaded with the delivered vector only if that vector is contributory, 14 or 8. Any other delivered vector leaves the history unchanged.
- R7: A generic request (`req_kind`=0 or 3) with `req_swint`=1 skips escalation. It is delivered with its own vector, error code 0 and `out_swint`=1, and it leaves the history unchanged.
- R8: For a generic request, `out_next_ip` = `cur_ip` + `ip_addend`, taken modulo 2^32.
- R9: `req_kind`=1 (single-step trap) delivers vector 1 with error code 0, `out_swint`=0 and `out_next_ip`=`cur_ip`. It skips escalation and leaves the history unchanged.
- R10: `req_kind`=2 (misaligned access) is an exception of vector 13 with error code 0 and `out_next_ip`=`cur_ip`. It is subject to escalation like any other exception.
- R11: `delivery_done` empties the history. A request accepted in the same cycle is judged against an empty history.
- R12: Every accepted request gives exactly one `out_valid` pulse in the next cycle, and no pulse appears otherwise. In HALT, `req_ready` is 0 and requests are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request (READY state) |
| req_kind | input | 2 | 0/3 generic, 1 single-step trap, 2 misaligned access |
| req_vector | input | 8 | Vector for generic requests |
| req_error | input | 32 | Error code for generic requests |
| req_swint | input | 1 | Generic request is a software interrupt |
| cur_ip | input | 32 | Current instruction pointer |
| ip_addend | input | 4 | Instruction length added for generic requests |
| guest_mode | input | 1 | Core runs a guest |
| delivery_done | input | 1 | Delivery complete: clear history, release HALT |
| out_valid | output | 1 | Result pulse |
| out_vector | output | 8 | Delivered vector (0 on halt) |
| out_error | output | 32 | Delivered error code |
| out_swint | output | 1 | Delivered as software interrupt |
| out_halt | output | 1 | Triple fault, no vector delivered |
| out_next_ip | output | 32 | Next instruction pointer |
| shutdown_req | output | 1 | Triple-fault shutdown request (held in HALT) |
| guest_exit_req | output | 1 | Triple-fault guest exit request (held in HALT) |

## Verification
The coinciding functions are the history clear from `delivery_done` and the escalation decision for a new request. They can fall in the same cycle, which a directed case provokes: vector 13 is followed by vector 12 with `delivery_done` high in the same cycle, and the case passes only if 12 comes out unescalated. The random phase raises `delivery_done` in about one cycle in six, independently of requests, and also while in HALT. A bench model applies clear-before-judge ordering and predicts every field, so any reversal of that ordering shows up as a vector 8 that was not expected.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;

    typedef enum logic [1:0] {
        KIND_GENERIC = 2'd0,
        KIND_STEP    = 2'd1,
        KIND_ALIGN   = 2'd2,
        KIND_ALT     = 2'd3
    } req_kind_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_HALT  = 1'b1
    } esc_state_e;

    localparam logic [31:0] VEC_DOUBLE     = 32'd8;
    localparam logic [31:0] VEC_PAGE       = 32'd14;
    localparam logic [31:0] VEC_STEP       = 32'd1;
    localparam logic [31:0] VEC_GPROT      = 32'd13;
    localparam logic [31:0] VEC_CONTRIB_LO = 32'd10;
    localparam logic [31:0] VEC_CONTRIB_HI = 32'd13;

    function automatic logic is_contrib(input logic [31:0] v);
        return (v == 32'd0) || (v >= VEC_CONTRIB_LO && v <= VEC_CONTRIB_HI);
    endfunction

    function automatic logic is_tracked(input logic [31:0] v);
        return is_contrib(v) || (v == VEC_PAGE) || (v == VEC_DOUBLE);
    endfunction

endpackage

// File: rtl/exc_esc_classify.sv
module exc_esc_classify
    import exc_esc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int ERR_W = 32,
    parameter int IP_W  = 32,
    parameter int ADD_W = 4
) (
    input  logic [1:0]       kind,
    input  logic [VEC_W-1:0] vec,
    input  logic [ERR_W-1:0] err,
    input  logic             swint,
    input  logic [IP_W-1:0]  cur_ip,
    input  logic [ADD_W-1:0] addend,
    input  logic             hist_valid,
    input  logic [VEC_W-1:0] hist_vec,
    output logic [VEC_W-1:0] res_vec,
    output logic [ERR_W-1:0] res_err,
    output logic             res_swint,
    output logic [IP_W-1:0]  res_next_ip,
    output logic             res_triple,
    output logic             res_track
);
    localparam int PAD_W = IP_W - ADD_W;

    logic [IP_W-1:0]  ip_plus;
    logic [31:0]      prev_w;
    logic [31:0]      new_w;
    logic [VEC_W-1:0] exc_vec;
    logic [ERR_W-1:0] exc_err;
    logic             exc_path;
    logic             escalate;

    assign ip_plus = cur_ip + {{PAD_W{1'b0}}, addend};
    assign prev_w  = 32'(hist_vec);

    always_comb begin
        exc_vec     = vec;
        exc_err     = err;
        exc_path    = 1'b0;
        res_vec     = vec;
        res_err     = err;
        res_swint   = 1'b0;
        res_next_ip = ip_plus;
        unique case (req_kind_e'(kind))
            KIND_STEP: begin
                res_vec     = VEC_W'(VEC_STEP);
                res_err     = '0;
                res_next_ip = cur_ip;
            end
            KIND_ALIGN: begin
                exc_vec     = VEC_W'(VEC_GPROT);
                exc_err     = '0;
                exc_path    = 1'b1;
                res_next_ip = cur_ip;
            end
            KIND_GENERIC, KIND_ALT: begin
                if (swint) begin
                    res_err   = '0;
                    res_swint = 1'b1;
                end else begin
                    exc_path = 1'b1;
                end
            end
        endcase

        new_w      = 32'(exc_vec);
        res_triple = exc_path && hist_valid && (prev_w == VEC_DOUBLE);
        escalate   = hist_valid && (
                        (is_contrib(prev_w) && is_contrib(new_w)) ||
                        ((prev_w == VEC_PAGE) &&
                         (is_contrib(new_w) || new_w == VEC_PAGE)));
        res_track  = 1'b0;

        if (exc_path) begin
            if (res_triple) begin
                res_vec = '0;
                res_err = '0;
            end else if (escalate) begin
                res_vec   = VEC_W'(VEC_DOUBLE);
                res_err   = '0;
                res_track = 1'b1;
            end else begin
                res_vec   = exc_vec;
                res_err   = exc_err;
                res_track = is_tracked(new_w);
            end
        end
    end
endmodule

// File: rtl/exc_esc_history.sv
module exc_esc_history
    import exc_esc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [VEC_W-1:0] load_vec,
    output logic             hist_valid,
    output logic [VEC_W-1:0] hist_vec
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_valid <= 1'b0;
            hist_vec   <= '0;
        end else if (load) begin
            hist_valid <= 1'b1;
            hist_vec   <= load_vec;
        end else if (clear) begin
            hist_valid <= 1'b0;
        end
    end

    AST_HIST_RELEVANT: assert property (@(posedge clk) disable iff (!rst_n)
        hist_valid |-> is_tracked(32'(hist_vec)));  // R6
endmodule

// File: rtl/exc_esc_fsm.sv
module exc_esc_fsm
    import exc_esc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int ERR_W = 32,
    parameter int IP_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             ack,
    input  logic             guest,
    input  logic [VEC_W-1:0] res_vec,
    input  logic [ERR_W-1:0] res_err,
    input  logic             res_swint,
    input  logic [IP_W-1:0]  res_next_ip,
    input  logic             res_triple,
    output logic             accept,
    output logic             req_ready,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vector,
    output logic [ERR_W-1:0] out_error,
    output logic             out_swint,
    output logic             out_halt,
    output logic [IP_W-1:0]  out_next_ip,
    output logic             shutdown_req,
    output logic             guest_exit_req
);
    esc_state_e state_q, state_d;
    logic       guest_q;

    assign req_ready      = (state_q == ST_READY);
    assign accept         = req_valid && req_ready;
    assign shutdown_req   = (state_q == ST_HALT) && !guest_q;
    assign guest_exit_req = (state_q == ST_HALT) && guest_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (accept && res_triple) state_d = ST_HALT;
            ST_HALT:  if (ack)                  state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            guest_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept && res_triple) guest_q <= guest;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_vector  <= '0;
            out_error   <= '0;
            out_swint   <= 1'b0;
            out_halt    <= 1'b0;
            out_next_ip <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_vector  <= res_vec;
                out_error   <= res_err;
                out_swint   <= res_swint;
                out_halt    <= res_triple;
                out_next_ip <= res_next_ip;
            end
        end
    end

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);  // R12
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !out_valid);  // R12
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_req || guest_exit_req) |-> !req_ready);  // R4
    AST_EXIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(shutdown_req && guest_exit_req));  // R5
    AST_HALT_SIGNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_halt) |-> (shutdown_req || guest_exit_req));  // R4
    AST_SWINT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_swint) |-> (out_error == '0));  // R7
endmodule

// File: rtl/exc_escalator.sv
module exc_escalator
    import exc_esc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int ERR_W = 32,
    parameter int IP_W  = 32,
    parameter int ADD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [VEC_W-1:0] req_vector,
    input  logic [ERR_W-1:0] req_error,
    input  logic             req_swint,
    input  logic [IP_W-1:0]  cur_ip,
    input  logic [ADD_W-1:0] ip_addend,
    input  logic             guest_mode,
    input  logic             delivery_done,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vector,
    output logic [ERR_W-1:0] out_error,
    output logic             out_swint,
    output logic             out_halt,
    output logic [IP_W-1:0]  out_next_ip,
    output logic             shutdown_req,
    output logic             guest_exit_req
);
    logic             hist_valid;
    logic [VEC_W-1:0] hist_vec;
    logic             hist_seen;
    logic [VEC_W-1:0] res_vec;
    logic [ERR_W-1:0] res_err;
    logic             res_swint;
    logic [IP_W-1:0]  res_next_ip;
    logic             res_triple;
    logic             res_track;
    logic             accept;

    // a completion in the same cycle empties the history before judging
    assign hist_seen = hist_valid && !delivery_done;

    exc_esc_classify #(
        .VEC_W(VEC_W), .ERR_W(ERR_W), .IP_W(IP_W), .ADD_W(ADD_W)
    ) u_classify (
        .kind(req_kind), .vec(req_vector), .err(req_error), .swint(req_swint),
        .cur_ip(cur_ip), .addend(ip_addend),
        .hist_valid(hist_seen), .hist_vec(hist_vec),
        .res_vec(res_vec), .res_err(res_err), .res_swint(res_swint),
        .res_next_ip(res_next_ip), .res_triple(res_triple), .res_track(res_track)
    );

    exc_esc_history #(.VEC_W(VEC_W)) u_history (
        .clk(clk), .rst_n(rst_n),
        .clear(delivery_done),
        .load(accept && res_track),
        .load_vec(res_vec),
        .hist_valid(hist_valid), .hist_vec(hist_vec)
    );

    exc_esc_fsm #(.VEC_W(VEC_W), .ERR_W(ERR_W), .IP_W(IP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .ack(delivery_done), .guest(guest_mode),
        .res_vec(res_vec), .res_err(res_err), .res_swint(res_swint),
        .res_next_ip(res_next_ip), .res_triple(res_triple),
        .accept(accept), .req_ready(req_ready),
        .out_valid(out_valid), .out_vector(out_vector), .out_error(out_error),
        .out_swint(out_swint), .out_halt(out_halt), .out_next_ip(out_next_ip),
        .shutdown_req(shutdown_req), .guest_exit_req(guest_exit_req)
    );

    AST_TRIPLE_NEEDS_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && res_triple) |-> (hist_valid && 32'(hist_vec) == VEC_DOUBLE));  // R4
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (delivery_done && !(accept && res_track)) |=> !hist_valid);  // R11
endmodule

// File: tb/exc_escalator_test.sv
`timescale 1ns/1ps
module exc_escalator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [7:0]  req_vector = 8'd0;
    logic [31:0] req_error = 32'd0;
    logic        req_swint = 1'b0;
    logic [31:0] cur_ip = 32'd0;
    logic [3:0]  ip_addend = 4'd0;
    logic        guest_mode = 1'b0;
    logic        delivery_done = 1'b0;
    logic        out_valid;
    logic [7:0]  out_vector;
    logic [31:0] out_error;
    logic        out_swint;
    logic        out_halt;
    logic [31:0] out_next_ip;
    logic        shutdown_req;
    logic        guest_exit_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model state
    bit          m_pv = 0;
    logic [7:0]  m_prev = 8'd0;
    bit          m_halt = 0;
    bit          m_guest = 0;
    bit          e_valid;
    logic [7:0]  e_vec;
    logic [31:0] e_err;
    bit          e_sw;
    bit          e_halt;
    logic [31:0] e_ip;
    string       e_tag;

    always #4 clk = ~clk;

    exc_escalator uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_vector(req_vector), .req_error(req_error),
        .req_swint(req_swint), .cur_ip(cur_ip), .ip_addend(ip_addend),
        .guest_mode(guest_mode), .delivery_done(delivery_done),
        .out_valid(out_valid), .out_vector(out_vector), .out_error(out_error),
        .out_swint(out_swint), .out_halt(out_halt), .out_next_ip(out_next_ip),
        .shutdown_req(shutdown_req), .guest_exit_req(guest_exit_req)
    );

    function automatic bit contrib(input logic [7:0] v);
        return (v == 8'd0) || (v >= 8'd10 && v <= 8'd13);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // model: updates history/state and sets expected result for this cycle
    task automatic model(input logic [1:0] k, input logic [7:0] v, input logic [31:0] e,
                         input logic sw, input logic [31:0] ip, input logic [3:0] ad,
                         input logic g, input logic dn, input logic vl);
        bit hv;
        bit exc;
        bit esc;
        logic [7:0] nv;
        logic [31:0] ne;
        e_valid = 0;
        if (m_halt) begin
            if (dn) begin m_halt = 0; m_pv = 0; end
            return;
        end
        hv = m_pv && !dn;
        if (dn) m_pv = 0;
        if (!vl) return;
        e_valid = 1;
        e_halt = 0;
        e_sw = 0;
        exc = 0;
        nv = v;
        ne = e;
        e_ip = ip + {28'd0, ad};
        e_tag = "R8";
        if (k == 2'd1) begin
            e_vec = 8'd1; e_err = 0; e_ip = ip; e_tag = "R9";
        end else if (k == 2'd2) begin
            nv = 8'd13; ne = 0; e_ip = ip; exc = 1; e_tag = "R10";
        end else if (sw) begin
            e_vec = v; e_err = 0; e_sw = 1; e_tag = "R7";
        end else begin
            exc = 1;
        end
        if (exc) begin
            esc = hv && ((contrib(m_prev) && contrib(nv)) ||
                         (m_prev == 8'd14 && (contrib(nv) || nv == 8'd14)));
            if (hv && m_prev == 8'd8) begin
                e_vec = 0; e_err = 0; e_halt = 1;
                m_halt = 1; m_guest = g;
                e_tag = g ? "R5" : "R4";
            end else begin
                if (esc) begin
                    e_vec = 8'd8; e_err = 0;
                    e_tag = (m_prev == 8'd14) ? "R3" : "R2";
                end else begin
                    e_vec = nv; e_err = ne;
                end
                if (contrib(e_vec) || e_vec == 8'd14 || e_vec == 8'd8) begin
                    m_pv = 1; m_prev = e_vec;
                end
            end
        end
    endtask

    // called at a negedge; returns at the next negedge after checking
    task automatic step(input logic [1:0] k, input logic [7:0] v, input logic [31:0] e,
                        input logic sw, input logic [31:0] ip, input logic [3:0] ad,
                        input logic g, input logic dn, input logic vl, input string tag);
        string t;
        req_kind = k; req_vector = v; req_error = e; req_swint = sw;
        cur_ip = ip; ip_addend = ad; guest_mode = g; delivery_done = dn; req_valid = vl;
        chk("R12", "req_ready", {63'd0, req_ready}, {63'd0, !m_halt});
        model(k, v, e, sw, ip, ad, g, dn, vl);
        @(posedge clk);
        @(negedge clk);
        t = (tag != "") ? tag : e_tag;
        chk("R12", "out_valid", {63'd0, out_valid}, {63'd0, e_valid});
        if (e_valid) begin
            chk(t, "vector", {56'd0, out_vector}, {56'd0, e_vec});
            chk(t, "error", {32'd0, out_error}, {32'd0, e_err});
            chk(t, "swint", {63'd0, out_swint}, {63'd0, e_sw});
            chk(t, "halt", {63'd0, out_halt}, {63'd0, e_halt});
            if (!e_halt) chk(t, "next_ip", {32'd0, out_next_ip}, {32'd0, e_ip});
        end
        chk("R4", "shutdown_req", {63'd0, shutdown_req}, {63'd0, m_halt && !m_guest});
        chk("R5", "guest_exit_req", {63'd0, guest_exit_req}, {63'd0, m_halt && m_guest});
        req_valid = 0; delivery_done = 0;
    endtask

    task automatic exc(input logic [7:0] v, input logic [31:0] e, input string tag);
        step(2'd0, v, e, 1'b0, 32'h1000, 4'd2, 1'b0, 1'b0, 1'b1, tag);
    endtask

    task automatic done_pulse();
        step(2'd0, 8'd0, 32'd0, 1'b0, 32'd0, 4'd0, 1'b0, 1'b1, 1'b0, "R11");
    endtask

    function automatic logic [7:0] pick_vec();
        case ($urandom % 12)
            0: return 8'd0;
            1: return 8'd8;
            2: return 8'd10;
            3: return 8'd11;
            4: return 8'd12;
            5: return 8'd13;
            6, 7: return 8'd14;
            8: return 8'd1;
            9: return 8'd3;
            default: return 8'($urandom % 32);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid", {63'd0, out_valid}, 64'd0);
        chk("R1", "req_ready", {63'd0, req_ready}, 64'd1);
        chk("R1", "shutdown_req", {63'd0, shutdown_req}, 64'd0);
        chk("R1", "guest_exit_req", {63'd0, guest_exit_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        exc(8'd13, 32'hABCD, "R1");            // empty history: 13 passes
        exc(8'd10, 32'h77, "R2");              // contributory on contributory
        exc(8'd5, 32'h1, "R4");                // triple fault
        step(2'd0, 8'd3, 32'd0, 1'b0, 32'd0, 4'd0, 1'b0, 1'b0, 1'b1, "R12"); // held off
        done_pulse();
        exc(8'd14, 32'h2, "R1");
        exc(8'd14, 32'h3, "R3");               // page on page
        done_pulse();
        exc(8'd14, 32'h4, "R3");
        exc(8'd3, 32'h55, "R3");               // not escalated
        exc(8'd0, 32'h9, "R6");                // history still 14
        done_pulse();
        exc(8'd11, 32'h1, "");
        exc(8'd12, 32'h1, "R2");
        step(2'd0, 8'd2, 32'd0, 1'b0, 32'h10, 4'd1, 1'b1, 1'b0, 1'b1, "R5");
        done_pulse();
        exc(8'd12, 32'h1, "");
        step(2'd0, 8'd13, 32'h55, 1'b1, 32'h200, 4'd2, 1'b0, 1'b0, 1'b1, "R7");
        exc(8'd10, 32'h6, "R7");               // history still 12
        done_pulse();
        exc(8'd12, 32'h1, "");
        step(2'd1, 8'd9, 32'h99, 1'b1, 32'h300, 4'd7, 1'b0, 1'b0, 1'b1, "R9");
        exc(8'd11, 32'h6, "R9");
        done_pulse();
        exc(8'd0, 32'h1, "");
        step(2'd2, 8'd3, 32'h12, 1'b0, 32'h400, 4'd3, 1'b0, 1'b0, 1'b1, "R10");
        done_pulse();
        step(2'd2, 8'd3, 32'h12, 1'b0, 32'h404, 4'd3, 1'b0, 1'b0, 1'b1, "R10");
        exc(8'd13, 32'h1, "");
        step(2'd0, 8'd12, 32'h42, 1'b0, 32'h500, 4'd1, 1'b0, 1'b1, 1'b1, "R11");
        done_pulse();
        step(2'd0, 8'd3, 32'h1, 1'b0, 32'hFFFF_FFFE, 4'd5, 1'b0, 1'b0, 1'b1, "R8");
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] k;
            k = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'd0;
            step(k, pick_vec(), $urandom, ($urandom % 8) == 0, $urandom,
                 4'($urandom), ($urandom % 4) == 0, ($urandom % 6) == 0,
                 ($urandom % 4) != 0, "");
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule